// File: doc/BRIEF.md
# Long Copy Chunk Splitter

This block sits in front of a memory-to-memory copy engine that can only move a bounded number of bytes per command. It takes one parent copy request, made of a source address, a destination address and a total byte count, and breaks it into a series of chunk commands. Each chunk is at most `MAX_CHUNK` bytes long. Every chunk starts where the previous one ended, in both the source and the destination space.

The engine reports each finished chunk with a one-cycle pulse, and chunks finish in the order they were issued. The block keeps a live residue for the parent. The residue starts at the full length and goes down only when a chunk is reported finished, not when it is issued. The block raises a single parent-completion pulse when the residue reaches zero. A status reader can sample the residue at any time.

Only one parent is in flight at a time. A zero-length request is taken off the request interface and dropped without any other effect.

Top module: `chunk_splitter`

## Requirements
- R1: After reset, `req_ready` is 1, `cmd_valid` is 0, `parent_done` is 0 and `residue` is 0.
- R2: The block issues ceil(L / MAX_CHUNK) chunk commands for a request of length L. The length of each chunk is the smaller of the bytes not yet issued and MAX_CHUNK. After the last chunk is taken, `cmd_valid` is low.
- R3: The first chunk carries the request's source and destination. Each later chunk's addresses equal the previous chunk's addresses plus the previous chunk's length, modulo 2^ADDR_W.
- R4: In the cycle after a request is accepted, `residue` equals the full length. Issuing a chunk leaves `residue` unchanged. Each accepted `chunk_done` lowers `residue` by the length of the oldest unfinished chunk, and the new value is visible in the next cycle.
- R5: `parent_done` is a one-cycle pulse, high in the cycle after the `chunk_done` that brings `residue` to zero. `residue` reads 0 while the pulse is high. `parent_done` is never high after an intermediate chunk.
- R6: A request with length 0 is consumed. It produces no chunk command and no `parent_done`, `residue` stays 0 and `req_ready` stays 1.
- R7: `req_ready` is low from the cycle after a non-zero request is accepted until the cycle in which `parent_done` is high. A request presented while `req_ready` is low has no effect on `residue` or on the chunk commands.
- R8: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_src`, `cmd_dst` and `cmd_len` hold their values into the next cycle.
- R9: A `chunk_done` pulse that arrives while no issued chunk is unfinished is ignored. `residue` is unchanged in the next cycle.
- R10: Whenever `cmd_valid` is high, `cmd_len` is non-zero and no larger than MAX_CHUNK.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Parent request offered |
| req_ready | output | 1 | Block can take a parent request |
| req_src | input | ADDR_W | Parent source start address |
| req_dst | input | ADDR_W | Parent destination start address |
| req_len | input | LEN_W | Parent byte count |
| cmd_valid | output | 1 | Chunk command offered to the engine |
| cmd_ready | input | 1 | Engine takes the chunk command |
| cmd_src | output | ADDR_W | Chunk source address |
| cmd_dst | output | ADDR_W | Chunk destination address |
| cmd_len | output | CHUNK_W | Chunk byte count |
| chunk_done | input | 1 | Engine finished the oldest outstanding chunk |
| parent_done | output | 1 | Whole parent finished (one-cycle pulse) |
| residue | output | LEN_W | Bytes of the parent not yet reported finished |

## Verification
The assertions assume that the engine finishes chunks strictly in issue order, so the length of a finishing chunk can be inferred from the residue. They also assume that `chunk_done` is never pulsed for a chunk that was not handed over. An unmatched pulse is tolerated, and R9 checks that it is ignored. The stimulus respects the ordering assumption: it hands over all chunks of a parent with a varying number of stall cycles, then reports them finished one by one. It sends spurious completion pulses only when no chunk is outstanding, and it presents an intruding request only while the block is busy. The lengths swept cover zero, values below, at and across multiples of a small MAX_CHUNK, and the largest representable length. The address sweep includes wrap-around of the address space.

// File: rtl/splitter_pkg.sv
package splitter_pkg;

  typedef enum logic {
    SPL_IDLE = 1'b0,
    SPL_RUN  = 1'b1
  } spl_state_e;

endpackage

// File: rtl/chunk_issuer.sv
module chunk_issuer #(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 32,
  parameter int MAX_CHUNK = 268435455,
  parameter int CHUNK_W   = 28
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [ADDR_W-1:0]  load_src_i,
  input  logic [ADDR_W-1:0]  load_dst_i,
  input  logic [LEN_W-1:0]   load_len_i,
  output logic               cmd_valid_o,
  input  logic               cmd_ready_i,
  output logic [ADDR_W-1:0]  cmd_src_o,
  output logic [ADDR_W-1:0]  cmd_dst_o,
  output logic [CHUNK_W-1:0] cmd_len_o,
  output logic               issue_fire_o
);

  localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_CHUNK);

  logic [ADDR_W-1:0] src_q, src_d;
  logic [ADDR_W-1:0] dst_q, dst_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic [LEN_W-1:0]  chunk_len;
  logic              upd_en;

  // next-state
  always_comb begin
    chunk_len    = (rem_q > MAX_L) ? MAX_L : rem_q;
    cmd_valid_o  = (rem_q != '0);
    issue_fire_o = cmd_valid_o && cmd_ready_i;
    upd_en       = load_i || issue_fire_o;
    src_d        = src_q;
    dst_d        = dst_q;
    rem_d        = rem_q;
    if (load_i) begin
      src_d = load_src_i;
      dst_d = load_dst_i;
      rem_d = load_len_i;
    end else if (issue_fire_o) begin
      src_d = src_q + ADDR_W'(chunk_len);
      dst_d = dst_q + ADDR_W'(chunk_len);
      rem_d = rem_q - chunk_len;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
      rem_q <= '0;
    end else if (upd_en) begin
      src_q <= src_d;
      dst_q <= dst_d;
      rem_q <= rem_d;
    end
  end

  assign cmd_src_o = src_q;
  assign cmd_dst_o = dst_q;
  assign cmd_len_o = chunk_len[CHUNK_W-1:0];

  assert_len_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> (cmd_len_o != '0) && (LEN_W'(cmd_len_o) <= MAX_L));

  assert_cmd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && !cmd_ready_i) |=>
      (cmd_valid_o && $stable(cmd_src_o) && $stable(cmd_dst_o) && $stable(cmd_len_o)));

endmodule

// File: rtl/residue_tracker.sv
module residue_tracker #(
  parameter int LEN_W     = 32,
  parameter int MAX_CHUNK = 268435455
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [LEN_W-1:0] load_len_i,
  input  logic             issue_fire_i,
  input  logic             chunk_done_i,
  output logic [LEN_W-1:0] residue_o,
  output logic             final_o,
  output logic             parent_done_o
);

  localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_CHUNK);

  logic [LEN_W-1:0] res_q, res_d;
  logic [LEN_W-1:0] outs_q, outs_d;
  logic             done_q, done_d;
  logic             take;
  logic             upd_en;

  // next-state: chunks finish in order, so the finishing length is min(res, MAX)
  always_comb begin
    take    = chunk_done_i && (outs_q != '0);
    final_o = take && (res_q <= MAX_L);
    done_d  = final_o;
    upd_en  = load_i || take || issue_fire_i;
    res_d   = res_q;
    outs_d  = outs_q;
    if (load_i) begin
      res_d  = load_len_i;
      outs_d = '0;
    end else begin
      if (take) res_d = final_o ? '0 : (res_q - MAX_L);
      case ({issue_fire_i, take})
        2'b10:   outs_d = outs_q + 1'b1;
        2'b01:   outs_d = outs_q - 1'b1;
        default: outs_d = outs_q;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q  <= '0;
      outs_q <= '0;
    end else if (upd_en) begin
      res_q  <= res_d;
      outs_q <= outs_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_d;
  end

  assign residue_o     = res_q;
  assign parent_done_o = done_q;

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    parent_done_o |=> !parent_done_o);

  assert_done_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    parent_done_o |-> (residue_o == '0));

  assert_residue_falls_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> (residue_o <= $past(residue_o)));

  assert_spurious_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (chunk_done_i && (outs_q == '0) && !load_i) |=> (residue_o == $past(residue_o)));

endmodule

// File: rtl/chunk_splitter.sv
module chunk_splitter #(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 32,
  parameter int MAX_CHUNK = 268435455,
  parameter int CHUNK_W   = $clog2(MAX_CHUNK + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_src,
  input  logic [ADDR_W-1:0]  req_dst,
  input  logic [LEN_W-1:0]   req_len,
  output logic               cmd_valid,
  input  logic               cmd_ready,
  output logic [ADDR_W-1:0]  cmd_src,
  output logic [ADDR_W-1:0]  cmd_dst,
  output logic [CHUNK_W-1:0] cmd_len,
  input  logic               chunk_done,
  output logic               parent_done,
  output logic [LEN_W-1:0]   residue
);
  import splitter_pkg::*;

  spl_state_e state_q, state_d;
  logic       accept, load, issue_fire, final_evt;

  always_comb begin
    req_ready = (state_q == SPL_IDLE);
    accept    = req_valid && req_ready;
    load      = accept && (req_len != '0);
    state_d   = state_q;
    case (state_q)
      SPL_IDLE: if (load)      state_d = SPL_RUN;
      SPL_RUN:  if (final_evt) state_d = SPL_IDLE;
      default:                 state_d = SPL_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SPL_IDLE;
    else        state_q <= state_d;
  end

  chunk_issuer #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_CHUNK(MAX_CHUNK), .CHUNK_W(CHUNK_W)
  ) u_issuer (
    .clk(clk), .rst_n(rst_n),
    .load_i(load), .load_src_i(req_src), .load_dst_i(req_dst), .load_len_i(req_len),
    .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready),
    .cmd_src_o(cmd_src), .cmd_dst_o(cmd_dst), .cmd_len_o(cmd_len),
    .issue_fire_o(issue_fire)
  );

  residue_tracker #(
    .LEN_W(LEN_W), .MAX_CHUNK(MAX_CHUNK)
  ) u_tracker (
    .clk(clk), .rst_n(rst_n),
    .load_i(load), .load_len_i(req_len),
    .issue_fire_i(issue_fire), .chunk_done_i(chunk_done),
    .residue_o(residue), .final_o(final_evt), .parent_done_o(parent_done)
  );

  assert_busy_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_len != '0)) |=> !req_ready);

  assert_zero_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_len == '0)) |=> (req_ready && !cmd_valid && !parent_done));

endmodule

// File: tb/chunk_splitter_tb.sv
module chunk_splitter_tb;

  localparam int  ADDR_W    = 16;
  localparam int  LEN_W     = 8;
  localparam int  MAX_CHUNK = 5;
  localparam int  CHUNK_W   = 3;
  localparam time CLK_PER   = 10ns;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               req_valid;
  logic               req_ready;
  logic [ADDR_W-1:0]  req_src, req_dst;
  logic [LEN_W-1:0]   req_len;
  logic               cmd_valid, cmd_ready;
  logic [ADDR_W-1:0]  cmd_src, cmd_dst;
  logic [CHUNK_W-1:0] cmd_len;
  logic               chunk_done;
  logic               parent_done;
  logic [LEN_W-1:0]   residue;

  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 1'b0;

  always #(CLK_PER / 2) clk = ~clk;

  chunk_splitter #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_CHUNK(MAX_CHUNK), .CHUNK_W(CHUNK_W)
  ) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_src(req_src), .req_dst(req_dst), .req_len(req_len),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_src(cmd_src), .cmd_dst(cmd_dst), .cmd_len(cmd_len),
    .chunk_done(chunk_done), .parent_done(parent_done), .residue(residue)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_parent(input int len, input logic [ADDR_W-1:0] s0, input logic [ADDR_W-1:0] d0);
    int nchunks;
    int left;
    int res;
    logic [ADDR_W-1:0] es, ed;
    nchunks = (len + MAX_CHUNK - 1) / MAX_CHUNK;
    @(negedge clk);
    chk(req_ready == 1'b1, "R7 ready before request", req_ready, 1);
    req_valid = 1'b1; req_src = s0; req_dst = d0; req_len = LEN_W'(len);
    @(negedge clk);
    req_valid = 1'b0;
    if (len == 0) begin
      for (int c = 0; c < 3; c++) begin
        chk(req_ready == 1'b1, "R6 ready after zero length", req_ready, 1);
        chk(cmd_valid == 1'b0, "R6 no chunk for zero length", cmd_valid, 0);
        chk(parent_done == 1'b0, "R6 no done for zero length", parent_done, 0);
        chk(residue == '0, "R6 residue zero", residue, 0);
        @(negedge clk);
      end
      return;
    end
    chk(residue == LEN_W'(len), "R4 residue loaded", residue, len);
    chk(req_ready == 1'b0, "R7 busy after accept", req_ready, 0);
    // spurious completion and an intruding request while nothing is outstanding
    chunk_done = 1'b1;
    req_valid = 1'b1; req_len = 8'd3; req_src = 16'h1234; req_dst = 16'h4321;
    @(negedge clk);
    chunk_done = 1'b0; req_valid = 1'b0;
    chk(residue == LEN_W'(len), "R9 spurious done ignored", residue, len);
    chk(req_ready == 1'b0, "R7 intruding request ignored", req_ready, 0);
    left = len; es = s0; ed = d0;
    for (int k = 0; k < nchunks; k++) begin
      int exp_len;
      int stall;
      exp_len = (left > MAX_CHUNK) ? MAX_CHUNK : left;
      stall = (len + k) % 3;
      for (int s = 0; s <= stall; s++) begin
        chk(cmd_valid == 1'b1, "R8 command held valid", cmd_valid, 1);
        chk(cmd_len == CHUNK_W'(exp_len), "R2 chunk length", cmd_len, exp_len);
        chk(cmd_src == es, "R3 chunk source", cmd_src, es);
        chk(cmd_dst == ed, "R3 chunk destination", cmd_dst, ed);
        if (s == stall) cmd_ready = 1'b1;
        @(negedge clk);
        cmd_ready = 1'b0;
      end
      left = left - exp_len;
      es = es + ADDR_W'(exp_len);
      ed = ed + ADDR_W'(exp_len);
      chk(residue == LEN_W'(len), "R4 residue unchanged by issue", residue, len);
    end
    chk(cmd_valid == 1'b0, "R2 chunk count", cmd_valid, 0);
    res = len;
    for (int k = 0; k < nchunks; k++) begin
      bit last;
      last = (k == nchunks - 1);
      chunk_done = 1'b1;
      @(negedge clk);
      chunk_done = 1'b0;
      res = res - ((res > MAX_CHUNK) ? MAX_CHUNK : res);
      chk(residue == LEN_W'(res), "R4 residue after completion", residue, res);
      chk(parent_done == last, "R5 parent done timing", parent_done, last);
      chk(req_ready == last, "R7 ready with parent done", req_ready, last);
    end
    @(negedge clk);
    chk(parent_done == 1'b0, "R5 done is one pulse", parent_done, 0);
    chunk_done = 1'b1;
    @(negedge clk);
    chunk_done = 1'b0;
    chk(residue == '0, "R9 done while idle ignored", residue, 0);
    chk(parent_done == 1'b0, "R9 no done while idle", parent_done, 0);
  endtask

  initial begin
    #(CLK_PER * 200000);
    if (!ended) begin
      ended = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_src = '0; req_dst = '0; req_len = '0;
    cmd_ready = 1'b0; chunk_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 reset ready", req_ready, 1);
    chk(cmd_valid == 1'b0, "R1 reset cmd_valid", cmd_valid, 0);
    chk(parent_done == 1'b0, "R1 reset parent_done", parent_done, 0);
    chk(residue == '0, "R1 reset residue", residue, 0);
    for (int l = 0; l <= 23; l++)
      run_parent(l, ADDR_W'(l * 997), ADDR_W'(16'hFFF8 - l));
    run_parent(254, 16'hFFFE, 16'h8000);
    run_parent(255, 16'h0001, 16'hFFFF);
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule